// File: doc/BRIEF.md
# Selectable-Precision ADC-to-DAC Sample Path

This block sits between a 12-bit two's-complement converter sample bus and a 14-bit unsigned DAC word. All of it runs in one main clock domain. Each sample is first reduced in precision: between zero and ten of its lowest bits are forced to zero. The sample is then placed in the upper bits of the DAC word with two zero bits below it. Its top bit is inverted, which turns the signed value into offset binary. The result is held in an output register that drives the DAC.

A bank of eight switches sets the precision level and the sample rate while the block runs. The switches are active low, so a switch that is ON reads 0. At full rate the output follows the input every clock. At reduced rate the output is refreshed once every 64 clocks and holds its value in between, a zero-order hold. With an 80 MHz clock this gives a 1.25 MHz sample rate. The switch bus passes through a two-stage synchronizer, and a new setting is taken up only at a sample boundary.

Top module: `precision_dac_path`

## Requirements
- R1: While the synchronous reset `rst_i` is high, the next clock edge sets `dac_o` to mid-scale 14'h2000. The same edge returns the rate to full and clears the decimation counter.
- R2: At full rate, `dac_o` equals `{adc_i, 2'b00}` with bit 13 inverted. It is taken from the `adc_i` value on the previous clock edge. For example, 12'h7FF gives 14'h3FFC, 12'h800 gives 14'h0000 and 12'h000 gives 14'h2000.
- R3: The number N of cleared sample bits is the inverted value of `sw_n_i[3:0]`, with bit 0 as the LSB. Bits N-1..0 of the sample are forced to zero before formatting. For example, N=2 on 12'h7FF gives 14'h3FF0, and N=10 on 12'hFFF gives 14'h1000.
- R4: Decoded levels from 11 to 15 clear exactly 10 bits. For example, `sw_n_i[3:0]`=4'h0 on 12'h7FF gives 14'h3000.
- R5: Every switch is active low. An input of 1 means OFF, and OFF is the control value 0. When `sw_n_i[4]` is 0, reduced rate is selected. Bits 7..5 have no effect.
- R6: At reduced rate, `dac_o` changes at most once in every 64 clocks and holds its value between updates.
- R7: A change on `sw_n_i` reaches the decoder two clocks later. At full rate it shows on `dac_o` one clock after that. At reduced rate it takes effect only at the next 64-clock sample boundary.
- R8: A 6-bit counter runs freely from reset. The reduced-rate update happens on the clock edge where the counter has counted 63. The first such edge is the 64th edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main sample clock |
| rst_i | input | 1 | Synchronous reset, active high |
| adc_i | input | 12 | Two's-complement converter sample |
| sw_n_i | input | 8 | Active-low switch bank, asynchronous |
| dac_o | output | 14 | Offset-binary DAC word, registered |

## Verification
The hardest situation to reach is a switch change that arrives in the middle of a reduced-rate hold window. The new level must not show until the next 64-clock boundary, while a change back to full rate must also wait for that boundary. The stimulus enters reduced rate and changes the precision switches at cycles that are not aligned to the counter. It then leaves reduced rate the same way, while the sample input changes on every clock. A behavioural reference model counts cycles since reset and tracks the two-cycle switch delay. Its prediction is compared with `dac_o` on every clock.

// File: rtl/precision_dac_pkg.sv
package precision_dac_pkg;
    typedef enum logic {
        RATE_FULL  = 1'b0,
        RATE_DECIM = 1'b1
    } rate_e;
endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] stab_q, stab_d;

    always_comb begin
        meta_d = async_i;
        stab_d = meta_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/rate_strobe.sv
module rate_strobe #(
    parameter int DECIM = 64,
    localparam int CNT_W = (DECIM > 1) ? $clog2(DECIM) : 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic             strobe_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DECIM - 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign strobe_o = (cnt_q == LAST);
    assign count_o  = cnt_q;
endmodule

// File: rtl/sample_fmt.sv
module sample_fmt #(
    parameter int ADC_W   = 12,
    parameter int DAC_W   = 14,
    parameter int LVL_W   = 4,
    parameter int MAX_CLR = 10,
    localparam int PAD_W  = DAC_W - ADC_W
) (
    input  logic [ADC_W-1:0] sample_i,
    input  logic [LVL_W-1:0] level_i,
    output logic [DAC_W-1:0] word_o
);
    localparam logic [LVL_W-1:0] CLR_CAP = LVL_W'(MAX_CLR);

    logic [LVL_W-1:0] clr_n;
    logic [ADC_W-1:0] keep_mask;
    logic [ADC_W-1:0] trimmed;

    // Clamp the requested depth to the supported maximum.
    always_comb begin
        if (level_i > CLR_CAP) begin
            clr_n = CLR_CAP;
        end else begin
            clr_n = level_i;
        end
    end

    for (genvar i = 0; i < ADC_W; i++) begin : g_mask
        assign keep_mask[i] = (i >= int'(clr_n));
    end

    assign trimmed = sample_i & keep_mask;

    // Left-align, pad with zeros, flip the sign bit to get offset binary.
    if (PAD_W > 0) begin : g_pad
        always_comb begin
            word_o = {trimmed, {PAD_W{1'b0}}};
            word_o[DAC_W-1] = ~word_o[DAC_W-1];
        end
    end else begin : g_nopad
        always_comb begin
            word_o = trimmed[ADC_W-1 -: DAC_W];
            word_o[DAC_W-1] = ~word_o[DAC_W-1];
        end
    end
endmodule

// File: rtl/precision_dac_path.sv
module precision_dac_path
    import precision_dac_pkg::*;
#(
    parameter int ADC_W    = 12,
    parameter int DAC_W    = 14,
    parameter int SW_W     = 8,
    parameter int LVL_W    = 4,
    parameter int MAX_CLR  = 10,
    parameter int RATE_BIT = 4,
    parameter int DECIM    = 64
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [ADC_W-1:0] adc_i,
    input  logic [SW_W-1:0]  sw_n_i,
    output logic [DAC_W-1:0] dac_o
);
    localparam int CNT_W = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam logic [DAC_W-1:0] MID_SCALE = {1'b1, {(DAC_W-1){1'b0}}};

    typedef struct packed {
        logic [DAC_W-1:0] dac;
        rate_e            rate;
    } path_t;

    path_t st_q, st_d;

    logic [SW_W-1:0]  sw_sync_n;
    logic [SW_W-1:0]  ctrl;
    logic             tick;
    logic [CNT_W-1:0] tick_cnt;
    logic [DAC_W-1:0] fmt_word;
    logic             load;

    sw_sync #(
        .W       (SW_W),
        .RST_VAL ({SW_W{1'b1}})
    ) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (sw_n_i),
        .sync_o  (sw_sync_n)
    );

    assign ctrl = ~sw_sync_n;

    rate_strobe #(
        .DECIM (DECIM)
    ) u_rate (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .strobe_o (tick),
        .count_o  (tick_cnt)
    );

    sample_fmt #(
        .ADC_W   (ADC_W),
        .DAC_W   (DAC_W),
        .LVL_W   (LVL_W),
        .MAX_CLR (MAX_CLR)
    ) u_fmt (
        .sample_i (adc_i),
        .level_i  (ctrl[LVL_W-1:0]),
        .word_o   (fmt_word)
    );

    // A sample boundary is every clock at full rate, every strobe otherwise.
    assign load = (st_q.rate == RATE_FULL) || tick;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.dac  = fmt_word;
            st_d.rate = ctrl[RATE_BIT] ? RATE_DECIM : RATE_FULL;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.dac  <= MID_SCALE;
            st_q.rate <= RATE_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_o = st_q.dac;
endmodule

// File: rtl/precision_dac_path_chk.sv
module precision_dac_path_chk #(
    parameter int DAC_W = 14,
    parameter int CNT_W = 6
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [DAC_W-1:0] dac_o,
    input logic             tick,
    input logic [CNT_W-1:0] tick_cnt,
    input logic             rate_slow
);
    // R1
    reset_midscale_chk: assert property (@(posedge clk_i)
        rst_i |=> (dac_o == {1'b1, {(DAC_W-1){1'b0}}}));

    // R2
    pad_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (dac_o[1:0] == 2'b00));

    // R6
    hold_between_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rate_slow && !tick) |=> $stable(dac_o));

    // R8
    wrap_after_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tick |=> (tick_cnt == '0));

    // R8
    no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tick |=> !tick);
endmodule

bind precision_dac_path precision_dac_path_chk #(
    .DAC_W (DAC_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .dac_o     (dac_o),
    .tick      (tick),
    .tick_cnt  (tick_cnt),
    .rate_slow (st_q.rate == precision_dac_pkg::RATE_DECIM)
);

// File: tb/precision_dac_path_tb.sv
module precision_dac_path_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] adc = '0;
    logic [7:0]  sw_n = 8'hFF;
    logic [13:0] dac;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit cmp_en = 0;
    string cur_req = "R2";

    // reference model state
    int m_s1 = 255, m_s2 = 255, m_cyc = 0, m_slow = 0, m_dac = 'h2000;

    always #2 clk = ~clk;

    precision_dac_path u_dut (
        .clk_i  (clk),
        .rst_i  (rst),
        .adc_i  (adc),
        .sw_n_i (sw_n),
        .dac_o  (dac)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Behavioural reference: cycles since reset, 2-cycle switch delay.
    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 255; m_s2 = 255; m_cyc = 0; m_slow = 0; m_dac = 'h2000;
        end else begin
            int ctrl, n, m;
            bit boundary;
            ctrl = (~m_s2) & 255;
            boundary = (m_cyc % 64) == 63;
            if (m_slow == 0 || boundary) begin
                n = ctrl & 15;
                if (n > 10) n = 10;
                m = int'(adc) & ~((1 << n) - 1) & 'hFFF;
                m_dac = ((m * 4) ^ 'h2000) & 'h3FFF;
                m_slow = (ctrl >> 4) & 1;
            end
            m_cyc++;
            m_s2 = m_s1;
            m_s1 = int'(sw_n);
        end
    end

    always @(negedge clk) begin
        if (cmp_en) check(cur_req, int'(dac), m_dac);
    end

    task automatic cycles(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    initial begin
        int changes;
        logic [13:0] prev;
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(dac), 'h2000);
        cmp_en = 1;
        // R2 format at full rate
        adc = 12'h7FF; @(negedge clk); check("R2", int'(dac), 'h3FFC);
        adc = 12'h800; @(negedge clk); check("R2", int'(dac), 'h0000);
        adc = 12'h000; @(negedge clk); check("R2", int'(dac), 'h2000);
        // R3 level 2 via active-low switches, R7 sync delay
        cur_req = "R3";
        adc = 12'h7FF; sw_n = ~8'h02;
        cycles(2); check("R7", int'(dac), 'h3FFC);
        @(negedge clk); check("R3", int'(dac), 'h3FF0);
        sw_n = ~8'h0A; adc = 12'hFFF; cycles(3);
        check("R3", int'(dac), 'h1000);
        // R4 clamp
        cur_req = "R4";
        sw_n = ~8'h0F; adc = 12'h7FF; cycles(3);
        check("R4", int'(dac), 'h3000);
        // R5 upper bits ignored
        cur_req = "R5";
        sw_n = ~8'hE0; adc = 12'h123; cycles(3);
        check("R5", int'(dac), 'h248C);
        for (int i = 0; i < 50; i++) begin adc = 12'($urandom); sw_n = 8'($urandom) | 8'h10; @(negedge clk); end
        // R6/R7 reduced rate, unaligned switch changes
        cur_req = "R6";
        sw_n = ~8'h13;
        cycles(70);
        changes = 0; prev = dac;
        for (int i = 0; i < 640; i++) begin
            adc = 12'($urandom);
            if (i == 200) sw_n = ~8'h15;
            if (i == 333) sw_n = ~8'h11;
            @(negedge clk);
            if (dac != prev) changes++;
            prev = dac;
        end
        checks++;
        if (changes > 10) begin
            fails++;
            $display("FAIL R6: got %0d changes expected at most 10", changes);
        end
        cur_req = "R7";
        sw_n = 8'hFF;
        for (int i = 0; i < 200; i++) begin adc = 12'($urandom); @(negedge clk); end
        // R8 first boundary after a fresh reset
        cur_req = "R8";
        rst = 1'b1; sw_n = ~8'h10; cycles(2);
        rst = 1'b0;
        for (int i = 0; i < 300; i++) begin adc = 12'($urandom); @(negedge clk); end
        cmp_en = 0;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(200000 * 4);
                checks++; fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule